// File: doc/BRIEF.md
# Operand Forwarding Select Unit

This block chooses the source of every operand that a five-stage pipeline reads late. For each of the two ALU operands of the instruction now in the execute stage, it picks one of three values: the register-file read, the ALU result waiting in the execute/memory register, or the result waiting in the memory/writeback register. For the store-data operand of the instruction now in the memory stage, it picks either the register-file value or the memory/writeback result. The second case covers a load that is followed directly by a store of the loaded register.

The unit looks only at register numbers, write enables and valid bits. It produces 2-bit select codes for muxes that sit outside it. A match needs a stage that holds a valid instruction, that will write the register file, and whose destination equals the source register. Register zero never matches. When both later stages match, the younger one wins. The unit does not need a path for a writer three instructions back, because the register file writes before it reads in the same cycle. The logic is combinational and keeps no state.

Top module: `fwd_select_unit`

## Requirements
- R1: Every select output uses the code 2'b00 for the register file, 2'b01 for the execute/memory result and 2'b10 for the memory/writeback result. The code 2'b11 never appears.
- R2: An ALU source register that equals the destination of a valid, writing instruction in the memory stage selects 2'b01.
- R3: An ALU source register that matches only the destination of a valid, writing instruction in the writeback stage selects 2'b10.
- R4: When both the memory-stage and the writeback-stage writers match an ALU source, the select is 2'b01, because the nearer writer wins.
- R5: A source register number of zero always selects 2'b00, even when a valid writer names register zero as its destination.
- R6: A stage whose valid bit is low is never a match. The select falls back to the other stage if that stage matches, or otherwise to 2'b00.
- R7: A stage whose write enable is low is never a match, whatever its destination number.
- R8: The store-data select is 2'b10 when the store register equals the destination of a valid, writing writeback-stage instruction and is not zero. Otherwise it is 2'b00. It is never 2'b01.
- R9: The two ALU operands are decided independently. Each operand may get a different code in the same cycle.
- R10: The selects depend only on the current inputs. The same inputs give the same codes whatever inputs came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a_i | input | REG_AW | First ALU source register of the execute-stage instruction |
| ex_src_b_i | input | REG_AW | Second ALU source register of the execute-stage instruction |
| mem_store_reg_i | input | REG_AW | Register holding the store data of the memory-stage instruction |
| mem_dst_i | input | REG_AW | Destination register of the memory-stage instruction |
| mem_wen_i | input | 1 | Memory-stage instruction writes the register file |
| mem_valid_i | input | 1 | Memory stage holds a real instruction |
| wb_dst_i | input | REG_AW | Destination register of the writeback-stage instruction |
| wb_wen_i | input | 1 | Writeback-stage instruction writes the register file |
| wb_valid_i | input | 1 | Writeback stage holds a real instruction |
| sel_a_o | output | 2 | Source select for the first ALU operand |
| sel_b_o | output | 2 | Source select for the second ALU operand |
| sel_store_o | output | 2 | Source select for the store-data operand |

## Verification
The unit has no state, so any fault shows up in the same cycle on the select codes. A wrong comparator or a missing gating term leaves a stale register value in an operand: the code reads 2'b00 where a forward was due, or it points at a stage that holds a bubble. A swapped priority shows when both later stages write the same register, where the older result would be chosen. The bench therefore drives cases where both stages collide, cases on register zero and cases with enables held low, and adds many random register numbers drawn from a small range so that matches happen often.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF    = 2'b00,
    SEL_EXMEM = 2'b01,
    SEL_MEMWB = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] dst_i,
  input  logic              wen_i,
  input  logic              valid_i,
  output logic              hit_o
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic same_reg;
  logic live_writer;

  assign same_reg    = (src_i == dst_i);
  assign live_writer = valid_i & wen_i;
  assign hit_o       = same_reg & live_writer & (src_i != ZERO_REG);

  always_comb begin
    if (!$isunknown({src_i, valid_i, wen_i, hit_o})) begin
      p_zero_never_hits_r5: assert (!(hit_o && src_i == ZERO_REG));
      p_dead_stage_no_hit_r6: assert (!(hit_o && !valid_i));
      p_no_write_no_hit_r7: assert (!(hit_o && !wen_i));
    end
  end
endmodule

// File: rtl/fwd_prio.sv
module fwd_prio
  import fwd_pkg::*;
#(
  parameter bit HAS_NEAR = 1'b1
) (
  input  logic     near_hit_i,
  input  logic     far_hit_i,
  output fwd_sel_e sel_o
);
  generate
    if (HAS_NEAR) begin : g_two_src
      always_comb begin
        if (near_hit_i)     sel_o = SEL_EXMEM;
        else if (far_hit_i) sel_o = SEL_MEMWB;
        else                sel_o = SEL_RF;
      end
    end else begin : g_one_src
      logic unused_near;
      assign unused_near = near_hit_i;
      always_comb sel_o = far_hit_i ? SEL_MEMWB : SEL_RF;
    end
  endgenerate

  always_comb begin
    if (!$isunknown({near_hit_i, far_hit_i, sel_o})) begin
      p_legal_code_r1: assert (sel_o != fwd_sel_e'(2'b11));
      p_far_only_when_near_miss_r4: assert (!(sel_o == SEL_MEMWB && HAS_NEAR && near_hit_i));
      p_far_needs_hit_r3: assert (!(sel_o == SEL_MEMWB && !far_hit_i));
      p_rf_means_no_hit_r2: assert (!(sel_o == SEL_RF && far_hit_i));
    end
  end
endmodule

// File: rtl/fwd_select_unit.sv
module fwd_select_unit
  import fwd_pkg::*;
#(
  parameter int REG_AW      = 5,
  parameter int NUM_ALU_SRC = 2
) (
  input  logic [REG_AW-1:0] ex_src_a_i,
  input  logic [REG_AW-1:0] ex_src_b_i,
  input  logic [REG_AW-1:0] mem_store_reg_i,
  input  logic [REG_AW-1:0] mem_dst_i,
  input  logic              mem_wen_i,
  input  logic              mem_valid_i,
  input  logic [REG_AW-1:0] wb_dst_i,
  input  logic              wb_wen_i,
  input  logic              wb_valid_i,
  output logic [1:0]        sel_a_o,
  output logic [1:0]        sel_b_o,
  output logic [1:0]        sel_store_o
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic [REG_AW-1:0] alu_src [NUM_ALU_SRC];
  fwd_sel_e          alu_sel [NUM_ALU_SRC];
  logic [NUM_ALU_SRC-1:0] mem_hit;
  logic [NUM_ALU_SRC-1:0] wb_hit;

  assign alu_src[0] = ex_src_a_i;
  assign alu_src[1] = ex_src_b_i;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_ALU_SRC; gi++) begin : g_alu_op
      fwd_match #(.REG_AW(REG_AW)) u_mem_cmp (
        .src_i   (alu_src[gi]),
        .dst_i   (mem_dst_i),
        .wen_i   (mem_wen_i),
        .valid_i (mem_valid_i),
        .hit_o   (mem_hit[gi])
      );
      fwd_match #(.REG_AW(REG_AW)) u_wb_cmp (
        .src_i   (alu_src[gi]),
        .dst_i   (wb_dst_i),
        .wen_i   (wb_wen_i),
        .valid_i (wb_valid_i),
        .hit_o   (wb_hit[gi])
      );
      fwd_prio #(.HAS_NEAR(1'b1)) u_pick (
        .near_hit_i (mem_hit[gi]),
        .far_hit_i  (wb_hit[gi]),
        .sel_o      (alu_sel[gi])
      );
    end
  endgenerate

  logic     st_hit;
  fwd_sel_e st_sel;

  fwd_match #(.REG_AW(REG_AW)) u_store_cmp (
    .src_i   (mem_store_reg_i),
    .dst_i   (wb_dst_i),
    .wen_i   (wb_wen_i),
    .valid_i (wb_valid_i),
    .hit_o   (st_hit)
  );

  fwd_prio #(.HAS_NEAR(1'b0)) u_store_pick (
    .near_hit_i (1'b0),
    .far_hit_i  (st_hit),
    .sel_o      (st_sel)
  );

  assign sel_a_o     = alu_sel[0];
  assign sel_b_o     = alu_sel[1];
  assign sel_store_o = st_sel;

  always_comb begin
    if (!$isunknown({ex_src_a_i, mem_store_reg_i, mem_valid_i, mem_wen_i,
                     sel_a_o, sel_store_o, wb_valid_i})) begin
      p_store_never_near_r8: assert (sel_store_o != 2'b01);
      p_zero_src_rf_r5: assert (!(ex_src_a_i == ZERO_REG && sel_a_o != 2'b00));
      p_near_needs_live_mem_r6: assert (!(sel_a_o == 2'b01 && !(mem_valid_i && mem_wen_i)));
      p_store_needs_live_wb_r8: assert (!(sel_store_o == 2'b10 && !wb_valid_i));
    end
  end
endmodule

// File: tb/fwd_select_unit_tb.sv
module fwd_select_unit_tb_top;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [AW-1:0] src_a = '0, src_b = '0, st_reg = '0, m_dst = '0, w_dst = '0;
  logic m_wen = 1'b0, m_vld = 1'b0, w_wen = 1'b0, w_vld = 1'b0;
  logic [1:0] sel_a, sel_b, sel_st;

  fwd_select_unit #(.REG_AW(AW), .NUM_ALU_SRC(2)) dut_i (
    .ex_src_a_i (src_a), .ex_src_b_i (src_b), .mem_store_reg_i (st_reg),
    .mem_dst_i (m_dst), .mem_wen_i (m_wen), .mem_valid_i (m_vld),
    .wb_dst_i (w_dst), .wb_wen_i (w_wen), .wb_valid_i (w_vld),
    .sel_a_o (sel_a), .sel_b_o (sel_b), .sel_store_o (sel_st)
  );

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic [1:0] s;
    string      req;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [1:0] model_alu(logic [AW-1:0] s, logic [AW-1:0] md,
      logic mw, logic mv, logic [AW-1:0] wd, logic ww, logic wv);
    if (s != 0 && mv && mw && md == s) return 2'b01;
    if (s != 0 && wv && ww && wd == s) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [1:0] model_st(logic [AW-1:0] s, logic [AW-1:0] wd,
      logic ww, logic wv);
    return (s != 0 && wv && ww && wd == s) ? 2'b10 : 2'b00;
  endfunction

  task automatic drive(input logic [AW-1:0] a, input logic [AW-1:0] b,
      input logic [AW-1:0] st, input logic [AW-1:0] md, input logic mw,
      input logic mv, input logic [AW-1:0] wd, input logic ww, input logic wv,
      input string req);
    exp_t e;
    @(posedge clk);
    #1;
    src_a = a; src_b = b; st_reg = st;
    m_dst = md; m_wen = mw; m_vld = mv;
    w_dst = wd; w_wen = ww; w_vld = wv;
    e.a = model_alu(a, md, mw, mv, wd, ww, wv);
    e.b = model_alu(b, md, mw, mv, wd, ww, wv);
    e.s = model_st(st, wd, ww, wv);
    e.req = req;
    q.push_back(e);
  endtask

  task automatic cmp(input logic [1:0] act, input logic [1:0] exp,
      input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(sel_a, e.a, e.req, "sel_a");
      cmp(sel_b, e.b, e.req, "sel_b");
      cmp(sel_st, e.s, e.req, "sel_store");
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle pipeline: all selects 00, no 11 code (R1, R6)
    drive(5'd3, 5'd4, 5'd3, 5'd3, 1'b1, 1'b0, 5'd4, 1'b1, 1'b0, "R1");
    drive(5'd7, 5'd2, 5'd0, 5'd7, 1'b1, 1'b1, 5'd9, 1'b1, 1'b1, "R2");
    drive(5'd9, 5'd2, 5'd0, 5'd7, 1'b1, 1'b1, 5'd9, 1'b1, 1'b1, "R3");
    drive(5'd8, 5'd8, 5'd8, 5'd8, 1'b1, 1'b1, 5'd8, 1'b1, 1'b1, "R4");
    drive(5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b1, "R5");
    drive(5'd6, 5'd6, 5'd6, 5'd6, 1'b1, 1'b0, 5'd6, 1'b1, 1'b1, "R6");
    drive(5'd6, 5'd5, 5'd6, 5'd6, 1'b1, 1'b1, 5'd6, 1'b1, 1'b0, "R6");
    drive(5'd11, 5'd11, 5'd11, 5'd11, 1'b0, 1'b1, 5'd11, 1'b0, 1'b1, "R7");
    drive(5'd11, 5'd12, 5'd11, 5'd11, 1'b0, 1'b1, 5'd11, 1'b1, 1'b1, "R7");
    drive(5'd1, 5'd2, 5'd31, 5'd31, 1'b1, 1'b1, 5'd31, 1'b1, 1'b1, "R8");
    drive(5'd1, 5'd2, 5'd31, 5'd31, 1'b1, 1'b1, 5'd30, 1'b1, 1'b1, "R8");
    drive(5'd14, 5'd15, 5'd1, 5'd14, 1'b1, 1'b1, 5'd15, 1'b1, 1'b1, "R9");
    drive(5'd15, 5'd14, 5'd2, 5'd14, 1'b1, 1'b1, 5'd15, 1'b1, 1'b1, "R9");
    drive(5'd4, 5'd5, 5'd4, 5'd4, 1'b1, 1'b1, 5'd5, 1'b1, 1'b1, "R10");
    drive(5'd4, 5'd5, 5'd4, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, "R10");
    drive(5'd4, 5'd5, 5'd4, 5'd4, 1'b1, 1'b1, 5'd5, 1'b1, 1'b1, "R10");
    for (int i = 0; i < 400; i++) begin
      drive(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            5'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
            5'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), "R4");
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule